// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is the data mover of one DMA channel. The channel's settings are kept in a small control-structure memory outside the block. Each setting group is a control word plus two end pointers, and there is a primary group and an alternate group. When a trigger arrives, the engine asks a shared arbiter for the bus. Once it is granted, it reads the control word and both end pointers from that memory. It then copies items from a source read port to a destination write port, one item per cycle. After each burst it writes the control word back, with the count field set to the number of items still outstanding.

Item addresses are not kept in counters. They are derived from the end pointers and the outstanding count, so the control word written back is the only progress record. The next burst reloads everything from memory.

There are four modes:
- Stop runs nothing.
- Basic moves one burst per trigger.
- Auto-request finishes the whole transfer from one trigger, re-arbitrating between bursts.
- Ping-pong alternates between the two groups and raises an interrupt each time a group completes.

A configuration the engine cannot honour is refused with a sticky error flag.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the engine is idle. The arbitration request, both memory strobes, the transfer strobes, the done interrupt and the error flag are all low, and the primary group is the active group.
- R2: The control-structure address is {group, word}. Group is 0 for primary and 1 for alternate; word 0 is the control word, word 1 the source end pointer and word 2 the destination end pointer. Read data is valid in the same cycle as the address. After a grant, the engine reads word 0, then word 1, then word 2, one word per cycle. It never reads word 0 unless a grant was seen at the previous clock edge.
- R3: The control word fields are:
  - [31:30] destination increment
  - [29:28] destination size
  - [27:26] source increment
  - [25:24] source size
  - [21] destination protection
  - [18] source protection
  - [17:14] burst exponent n
  - [13:4] count minus one
  - [3] spare, kept
  - [2:0] mode (0 stop, 1 basic, 2 auto-request, 3 ping-pong)
  
  Sizes and increments use 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. An increment of 3 means no increment. The item_size output shows the source size while items move.
- R4: One item moves per cycle. Each item's address is the end pointer minus (outstanding items − 1) × (1 << increment); with an increment of 3 the address stays at the end pointer. Destination data equals the source read data in the same cycle.
- R5: A burst is the smaller of 2^n and the outstanding count. Any n of 10 or more gives 1024, so a transfer of up to 1024 items needs only one arbitration. A tail shorter than 2^n is finished as that shorter burst.
- R6: After each burst, the control word is written back to word 0 of the active group with every field unchanged, except that the count field holds outstanding − 1. On completion, the count field is 0 and the mode is 0.
- R7: In basic mode, each trigger moves exactly one burst. A trigger that arrives while the engine is busy is held, and one held trigger starts the next burst as soon as the engine is idle.
- R8: In auto-request mode, one trigger moves the whole transfer. Between bursts the arbitration request is raised again and the engine waits for a new grant.
- R9: A control word with mode 0 causes one control read, no item transfer and no write-back.
- R10: A configuration is invalid if the mode is 4 to 7, a size is 3, the two sizes differ, or an increment is smaller than its size. Such a configuration moves no items, writes back the word with mode 0, and sets the error flag, which stays set until reset.
- R11: done_irq is high for exactly one cycle, in the write-back cycle that completes a transfer.
- R12: Completing a ping-pong group makes the other group active. If the next control word loaded after such a switch is not in ping-pong mode, the engine halts: triggers are ignored and the arbitration request stays low until reset.
- R13: src_prot and dst_prot carry control bits 18 and 21 while items move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Transfer trigger, one-cycle pulse |
| gnt | input | 1 | Bus grant from the arbiter |
| arb_req | output | 1 | Request to the arbiter |
| cs_rd | output | 1 | Control-structure read strobe |
| cs_wr | output | 1 | Control-structure write strobe |
| cs_addr | output | 3 | Control-structure word address {group, word} |
| cs_wdata | output | 32 | Control word written back |
| cs_rdata | input | 32 | Control-structure read data, valid in the same cycle |
| src_rd | output | 1 | Source read strobe |
| src_addr | output | AW | Source item address |
| src_rdata | input | DW | Source read data, valid in the same cycle |
| src_prot | output | 1 | Source protection sideband |
| dst_wr | output | 1 | Destination write strobe |
| dst_addr | output | AW | Destination item address |
| dst_wdata | output | DW | Destination write data |
| item_size | output | 2 | Item size code |
| dst_prot | output | 1 | Destination protection sideband |
| done_irq | output | 1 | Transfer complete pulse |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
The delicate coincidence is a trigger that arrives in the same cycle as a completing write-back. This matters most in ping-pong mode, where that same cycle also switches the active group. The bench provokes it by watching done_irq and pulsing the trigger in that very cycle. A behavioural reference model, compared on every clock, then expects the held trigger to start a burst from the alternate group straight away, with the interrupt still one cycle wide. The same comparison covers triggers arriving mid-burst and grants withheld between auto-request bursts.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          gnt,
  output logic          arb_req,
  output logic          cs_rd,
  output logic          cs_wr,
  output logic [2:0]    cs_addr,
  output logic [31:0]   cs_wdata,
  input  logic [31:0]   cs_rdata,
  output logic          src_rd,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_rdata,
  output logic          src_prot,
  output logic          dst_wr,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_wdata,
  output logic [1:0]    item_size,
  output logic          dst_prot,
  output logic          done_irq,
  output logic          cfg_err
);

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_LDC, S_LDS, S_LDD, S_MOVE, S_WB, S_HALT} st_t;

  st_t st;
  logic sel_alt, pp_run, pend, bad, err_q;
  logic [31:0] ctl;
  logic [AW-1:0] s_end, d_end;
  logic [10:0] rem, blen;

  wire [2:0]  new_mode = cs_rdata[2:0];
  wire [1:0]  n_dinc   = cs_rdata[31:30];
  wire [1:0]  n_dsz    = cs_rdata[29:28];
  wire [1:0]  n_sinc   = cs_rdata[27:26];
  wire [1:0]  n_ssz    = cs_rdata[25:24];
  wire [3:0]  n_arb    = cs_rdata[17:14];
  wire        cfg_bad  = (new_mode > 3'd3) || (n_ssz == 2'd3) || (n_ssz != n_dsz) ||
                         (n_sinc < n_ssz) || (n_dinc < n_dsz);
  wire [10:0] n_cnt    = {1'b0, cs_rdata[13:4]} + 11'd1;
  wire [10:0] n_lim    = (n_arb > 4'd9) ? 11'd1024 : (11'd1 << n_arb);
  wire [10:0] n_blen   = (n_cnt < n_lim) ? n_cnt : n_lim;

  wire [10:0]   rem_dec = rem - 11'd1;
  wire [AW-1:0] s_off   = AW'(rem_dec) << ctl[27:26];
  wire [AW-1:0] d_off   = AW'(rem_dec) << ctl[31:30];
  wire          fin     = (rem == 11'd0);
  wire [9:0]    fld     = fin ? 10'd0 : rem_dec[9:0];
  wire [2:0]    wb_mode = (fin || bad) ? 3'd0 : ctl[2:0];

  assign arb_req   = (st == S_ARB);
  assign cs_rd     = (st == S_LDC) || (st == S_LDS) || (st == S_LDD);
  assign cs_wr     = (st == S_WB);
  assign cs_addr   = {sel_alt, (st == S_LDS) ? 2'd1 : (st == S_LDD) ? 2'd2 : 2'd0};
  assign cs_wdata  = {ctl[31:14], fld, ctl[3], wb_mode};
  assign src_rd    = (st == S_MOVE);
  assign dst_wr    = (st == S_MOVE);
  assign src_addr  = s_end - ((ctl[27:26] == 2'd3) ? '0 : s_off);
  assign dst_addr  = d_end - ((ctl[31:30] == 2'd3) ? '0 : d_off);
  assign dst_wdata = src_rdata;
  assign item_size = ctl[25:24];
  assign src_prot  = ctl[18];
  assign dst_prot  = ctl[21];
  assign done_irq  = (st == S_WB) && fin && !bad;
  assign cfg_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel_alt <= 1'b0;
      pp_run <= 1'b0;
      pend <= 1'b0;
      bad <= 1'b0;
      err_q <= 1'b0;
      ctl <= '0;
      s_end <= '0;
      d_end <= '0;
      rem <= '0;
      blen <= '0;
    end else begin
      if (trig && st != S_IDLE && st != S_HALT) pend <= 1'b1;
      case (st)
        S_IDLE: if (trig || pend) begin
          st <= S_ARB;
          pend <= 1'b0;
        end
        S_ARB: if (gnt) st <= S_LDC;
        S_LDC: begin
          ctl <= cs_rdata;
          rem <= n_cnt;
          blen <= n_blen;
          bad <= cfg_bad;
          if (pp_run && new_mode != 3'd3) st <= S_HALT;
          else if (new_mode == 3'd0)      st <= S_IDLE;
          else if (cfg_bad)               st <= S_WB;
          else                            st <= S_LDS;
        end
        S_LDS: begin
          s_end <= cs_rdata[AW-1:0];
          st <= S_LDD;
        end
        S_LDD: begin
          d_end <= cs_rdata[AW-1:0];
          st <= S_MOVE;
        end
        S_MOVE: begin
          rem <= rem_dec;
          blen <= blen - 11'd1;
          if (blen == 11'd1) st <= S_WB;
        end
        S_WB: begin
          bad <= 1'b0;
          if (bad) begin
            err_q <= 1'b1;
            st <= S_IDLE;
          end else if (fin) begin
            if (ctl[2:0] == 3'd3) begin
              sel_alt <= ~sel_alt;
              pp_run <= 1'b1;
            end
            st <= S_IDLE;
          end else if (ctl[2:0] == 3'd2) begin
            st <= S_ARB;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  logic [11:0] run_n;
  wire  [11:0] cap = (ctl[17:14] > 4'd9) ? 12'd1024 : (12'd1 << ctl[17:14]);
  always_ff @(posedge clk) begin
    if (!rst_n) run_n <= '0;
    else        run_n <= dst_wr ? run_n + 12'd1 : 12'd0;
  end

  AST_LOAD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rd && cs_addr[1:0] == 2'd0) |-> $past(arb_req && gnt)); // R2
  AST_ITEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr && $past(dst_wr) && ctl[31:30] != 2'd3) |-> dst_addr == $past(dst_addr) + (AW'(1) << ctl[31:30])); // R4
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr |-> run_n < cap); // R5
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (cs_wr && cs_wdata[2:0] == 3'd0 && cs_wdata[13:4] == 10'd0)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_HALT) |-> (!arb_req && !dst_wr && !cs_wr)); // R12

endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic slow = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  wire  gnt_en = slow ? lfsr[0] : 1'b1;

  logic arb_req, cs_rd, cs_wr, src_rd, src_prot, dst_wr, dst_prot, done_irq, cfg_err;
  logic [2:0] cs_addr;
  logic [31:0] cs_wdata, cs_rdata, src_addr, src_rdata, dst_addr, dst_wdata;
  logic [1:0] item_size;
  wire gnt = arb_req & gnt_en;

  logic [31:0] csm [8];
  logic pv = 1'b0;
  logic [2:0] pi = '0;
  logic [31:0] pd = '0;
  assign cs_rdata  = csm[cs_addr];
  assign src_rdata = src_addr ^ 32'h5A5A_0000;

  dma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .gnt(gnt), .arb_req(arb_req),
    .cs_rd(cs_rd), .cs_wr(cs_wr), .cs_addr(cs_addr), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata),
    .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata), .src_prot(src_prot),
    .dst_wr(dst_wr), .dst_addr(dst_addr), .dst_wdata(dst_wdata), .item_size(item_size),
    .dst_prot(dst_prot), .done_irq(done_irq), .cfg_err(cfg_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) csm[i] <= '0;
    end else if (cs_wr) csm[cs_addr] <= cs_wdata;
    else if (pv) csm[pi] <= pd;
  end

  // behavioural reference: phase 0 idle,1 wait grant,2..4 loads,5 move,6 write-back,7 halted
  int ph;
  bit m_alt, m_pp, m_pend, m_bad, m_err;
  logic [31:0] m_cs [8];
  logic [31:0] m_ctl, m_se, m_de;
  int m_left, m_blen;

  function automatic logic [31:0] wb_word();
    logic [9:0] f;
    logic [2:0] md;
    f  = (m_left == 0) ? 10'd0 : 10'(m_left - 1);
    md = (m_left == 0 || m_bad) ? 3'd0 : m_ctl[2:0];
    return {m_ctl[31:14], f, m_ctl[3], md};
  endfunction

  function automatic logic [31:0] item_addr(logic [31:0] e, logic [1:0] inc);
    if (inc == 2'd3) return e;
    return e - 32'(m_left - 1) * (32'd1 << inc);
  endfunction

  always @(posedge clk) begin : mdl
    int md, cnt, ab, lim;
    logic [31:0] w;
    if (!rst_n) begin
      ph = 0; m_alt = 0; m_pp = 0; m_pend = 0; m_bad = 0; m_err = 0;
      m_ctl = '0; m_se = '0; m_de = '0; m_left = 0; m_blen = 0;
      for (int i = 0; i < 8; i++) m_cs[i] = '0;
    end else begin
      if (pv) m_cs[pi] = pd;
      if (trig && ph != 0 && ph != 7) m_pend = 1;
      case (ph)
        0: if (trig || m_pend) begin ph = 1; m_pend = 0; end
        1: if (gnt_en) ph = 2;
        2: begin
          m_ctl = m_cs[{m_alt, 2'd0}];
          md = int'(m_ctl[2:0]);
          cnt = int'(m_ctl[13:4]) + 1;
          ab = int'(m_ctl[17:14]);
          lim = (ab > 9) ? 1024 : (1 << ab);
          if (m_pp && md != 3) ph = 7;
          else if (md == 0) ph = 0;
          else begin
            m_left = cnt;
            m_blen = (cnt < lim) ? cnt : lim;
            m_bad = (md > 3) || (m_ctl[25:24] == 2'd3) || (m_ctl[25:24] != m_ctl[29:28]) ||
                    (m_ctl[27:26] < m_ctl[25:24]) || (m_ctl[31:30] < m_ctl[29:28]);
            ph = m_bad ? 6 : 3;
          end
        end
        3: begin m_se = m_cs[{m_alt, 2'd1}]; ph = 4; end
        4: begin m_de = m_cs[{m_alt, 2'd2}]; ph = 5; end
        5: begin
          m_left--; m_blen--;
          if (m_blen == 0) ph = 6;
        end
        6: begin
          w = wb_word();
          m_cs[{m_alt, 2'd0}] = w;
          if (m_bad) begin m_err = 1; ph = 0; end
          else if (m_left == 0) begin
            if (m_ctl[2:0] == 3'd3) begin m_alt = !m_alt; m_pp = 1; end
            ph = 0;
          end else ph = (m_ctl[2:0] == 3'd2) ? 1 : 0;
          m_bad = 0;
        end
        default: ph = 7;
      endcase
    end
  end

  int mt = 0, mb = 0, st_n = 0, sb = 0, cyc = 0;
  int n_dst = 0, n_done = 0, n_arb = 0;
  logic arb_prev = 1'b0;
  logic [31:0] last_dst = '0;

  function automatic int cmp(logic [31:0] a, logic [31:0] e, string tg);
    if (a !== e) begin
      $display("FAIL %s actual=%h expected=%h", tg, a, e);
      return 1;
    end
    return 0;
  endfunction

  always @(negedge clk) begin
    logic [31:0] es;
    cyc++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cyc > 150000) begin
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", mt + st_n + 1, mb + sb + 1);
      $finish;
    end
    if (rst_n) begin
      mb += cmp(32'(arb_req), 32'(ph == 1), "R8 arb_req"); mt++;
      mb += cmp(32'(cs_rd), 32'(ph >= 2 && ph <= 4), "R2 cs_rd"); mt++;
      mb += cmp(32'(cs_wr), 32'(ph == 6), "R6 cs_wr"); mt++;
      if (ph >= 2 && ph <= 4) begin
        mb += cmp(32'(cs_addr), 32'({m_alt, 2'(ph - 2)}), "R2 cs_addr"); mt++;
      end
      if (ph == 6) begin
        mb += cmp(32'(cs_addr), 32'({m_alt, 2'd0}), "R6 cs_addr"); mt++;
        mb += cmp(cs_wdata, wb_word(), "R6 cs_wdata"); mt++;
      end
      mb += cmp(32'(dst_wr), 32'(ph == 5), "R4 dst_wr"); mt++;
      mb += cmp(32'(src_rd), 32'(ph == 5), "R4 src_rd"); mt++;
      if (ph == 5) begin
        es = item_addr(m_se, m_ctl[27:26]);
        mb += cmp(src_addr, es, "R4 src_addr"); mt++;
        mb += cmp(dst_addr, item_addr(m_de, m_ctl[31:30]), "R4 dst_addr"); mt++;
        mb += cmp(dst_wdata, es ^ 32'h5A5A_0000, "R4 dst_wdata"); mt++;
        mb += cmp(32'(item_size), 32'(m_ctl[25:24]), "R3 item_size"); mt++;
        mb += cmp(32'(src_prot), 32'(m_ctl[18]), "R13 src_prot"); mt++;
        mb += cmp(32'(dst_prot), 32'(m_ctl[21]), "R13 dst_prot"); mt++;
      end
      mb += cmp(32'(done_irq), 32'(ph == 6 && m_left == 0 && !m_bad), "R11 done_irq"); mt++;
      mb += cmp(32'(cfg_err), 32'(m_err), "R10 cfg_err"); mt++;
    end
    if (dst_wr) begin n_dst++; last_dst = dst_addr; end
    if (done_irq) n_done++;
    if (arb_req && !arb_prev) n_arb++;
    arb_prev = arb_req;
  end

  task automatic chk(logic [31:0] a, logic [31:0] e, string tg);
    st_n++;
    if (a !== e) begin
      sb++;
      $display("FAIL %s actual=%h expected=%h", tg, a, e);
    end
  endtask

  task automatic put(logic [2:0] i, logic [31:0] v);
    @(negedge clk); pi = i; pd = v; pv = 1'b1;
    @(negedge clk); pv = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle(int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (ph == 0 && !m_pend && !trig) return;
    end
    chk(32'(ph), 32'd0, "idle timeout");
  endtask

  task automatic fire_on_done(int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (done_irq) begin
        trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        return;
      end
    end
    chk(0, 1, "R11 done never seen");
  endtask

  function automatic logic [31:0] mk(int dinc, int dsz, int sinc, int ssz, int dp, int sp,
                                     int arb, int xf, int mode);
    return {2'(dinc), 2'(dsz), 2'(sinc), 2'(ssz), 2'b00, 1'(dp), 2'b00, 1'(sp),
            4'(arb), 10'(xf), 1'b0, 3'(mode)};
  endfunction

  initial begin
    int b_dst, b_done, b_arb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(arb_req), 0, "R1 arb_req");
    chk(32'(cs_rd | cs_wr), 0, "R1 cs strobes");
    chk(32'(dst_wr | src_rd), 0, "R1 move strobes");
    chk(32'(done_irq), 0, "R1 done_irq");
    chk(32'(cfg_err), 0, "R1 cfg_err");

    // basic, word items, bursts of 2 over 5 items
    put(3'd0, mk(2, 2, 2, 2, 0, 1, 1, 4, 1));
    put(3'd1, 32'h0000_1000);
    put(3'd2, 32'h0000_2010);
    b_dst = n_dst; b_done = n_done;
    fire(); @(negedge clk); fire();
    wait_idle(300);
    chk(32'(n_dst - b_dst), 4, "R7 two bursts from trigger plus held trigger");
    chk(32'(n_done - b_done), 0, "R11 no done mid transfer");
    chk(csm[0], mk(2, 2, 2, 2, 0, 1, 1, 0, 1), "R6 outstanding one");
    fire(); wait_idle(300);
    chk(32'(n_dst - b_dst), 5, "R5 tail burst of one");
    chk(32'(n_done - b_done), 1, "R11 single done");
    chk(csm[0], mk(2, 2, 2, 2, 0, 1, 1, 0, 0), "R6 completion word");
    chk(last_dst, 32'h0000_2010, "R4 last item at end pointer");

    // auto-request, byte items, fixed destination, slow grants
    slow = 1'b1;
    put(3'd0, mk(3, 0, 0, 0, 1, 0, 2, 9, 2));
    put(3'd1, 32'h0000_3009);
    put(3'd2, 32'h0000_4000);
    b_dst = n_dst; b_done = n_done; b_arb = n_arb;
    fire(); wait_idle(2000);
    chk(32'(n_dst - b_dst), 10, "R8 whole transfer from one trigger");
    chk(32'(n_arb - b_arb), 3, "R8 re-arbitration per burst");
    chk(32'(n_done - b_done), 1, "R11 auto done");
    chk(last_dst, 32'h0000_4000, "R4 no-increment destination");
    chk(csm[0], mk(3, 0, 0, 0, 1, 0, 2, 0, 0), "R6 auto completion word");
    slow = 1'b0;

    // large exponent: one arbitration for 20 half-words
    put(3'd0, mk(1, 1, 1, 1, 0, 0, 12, 19, 2));
    put(3'd1, 32'h0000_5026);
    put(3'd2, 32'h0000_6026);
    b_dst = n_dst; b_arb = n_arb;
    fire(); wait_idle(500);
    chk(32'(n_dst - b_dst), 20, "R5 twenty items");
    chk(32'(n_arb - b_arb), 1, "R5 exponent above nine never re-arbitrates");

    // stop mode
    put(3'd0, mk(2, 2, 2, 2, 0, 0, 0, 3, 0));
    b_dst = n_dst;
    fire(); wait_idle(100);
    chk(32'(n_dst - b_dst), 0, "R9 no items in stop");
    chk(csm[0], mk(2, 2, 2, 2, 0, 0, 0, 3, 0), "R9 word untouched");
    chk(32'(cfg_err), 0, "R9 no error");

    // invalid: byte increment below word size
    put(3'd0, mk(0, 2, 0, 2, 0, 0, 0, 3, 1));
    b_dst = n_dst;
    fire(); wait_idle(100);
    chk(32'(n_dst - b_dst), 0, "R10 no items");
    chk(32'(cfg_err), 1, "R10 error set");
    chk(csm[0], mk(0, 2, 0, 2, 0, 0, 0, 3, 0), "R10 mode cleared");
    repeat (5) @(negedge clk);
    chk(32'(cfg_err), 1, "R10 error sticky");

    // ping-pong with trigger in the completion cycle
    put(3'd0, mk(2, 2, 2, 2, 0, 0, 3, 2, 3));
    put(3'd1, 32'h0000_7008);
    put(3'd2, 32'h0000_8008);
    put(3'd4, mk(0, 0, 0, 0, 1, 1, 0, 1, 3));
    put(3'd5, 32'h0000_9001);
    put(3'd6, 32'h0000_A001);
    b_dst = n_dst; b_done = n_done;
    fire(); fire_on_done(200); wait_idle(200);
    chk(32'(n_dst - b_dst), 4, "R12 held trigger runs alternate");
    chk(32'(n_done - b_done), 1, "R11 primary done");
    chk(last_dst, 32'h0000_A000, "R12 alternate first item");
    fire(); wait_idle(200);
    chk(32'(n_done - b_done), 2, "R12 alternate done");
    chk(csm[4], mk(0, 0, 0, 0, 1, 1, 0, 0, 0), "R6 alternate completion word");
    fire(); repeat (10) @(negedge clk);
    b_dst = n_dst; b_arb = n_arb;
    fire(); fire(); repeat (20) @(negedge clk);
    chk(32'(n_arb - b_arb), 0, "R12 halted ignores triggers");
    chk(32'(n_dst - b_dst), 0, "R12 halted moves nothing");

    $display("test done: total=%0d bad=%0d", mt + st_n, mb + sb);
    $finish;
  end
endmodule